// File: doc/BRIEF.md
# Externally Clocked Synchronous Serial Slave Port

This block links an instrument's internal logic to a host over four wires: a bit clock, a frame-sync pulse, a receive data line and a transmit data line. The host owns the bit clock, which toggles without pause, and the frame sync. The port is the slave: the transmit line is the only wire it drives. Each 16-bit word is announced by frame sync held high for exactly one bit period. The word's bits then follow in the next sixteen periods, most significant bit first. Receive and transmit share each frame and run at the same time.

All three host inputs are brought into the system clock domain through a synchronizer chain. The edges of the bit clock are found there. Receive data and frame sync are taken on falling edges, and the transmit line is updated after rising edges. The internal side has a parallel word output with a one-cycle valid strobe. It also has a transmit word input with a valid/ready handshake, backed by one holding register. The receive side uses a two-state machine, RX_IDLE and RX_SHIFT. Frame start moves RX_IDLE to RX_SHIFT. The sixteenth bit returns RX_SHIFT to RX_IDLE. A resync keeps RX_SHIFT and clears the bit count. The transmit side uses TX_IDLE, TX_ARMED and TX_SEND. Frame start moves any state to TX_ARMED. The first rising edge moves TX_ARMED to TX_SEND. The rising edge that drives the sixteenth bit moves TX_SEND to TX_IDLE.

Top module: `sync_serial_slave`

## Requirements
- R1: After reset the transmit line is 0, rx_valid_o is 0, tx_ready_o is 1 and tx_underrun_o is 0.
- R2: Frame sync is active high. A frame starts at a falling bit-clock edge where frame sync is 1. The sixteen falling edges that follow sample ser_rx_i, and the first sample is bit 15 of the word. After the sixteenth sample, rx_data_o holds the word and rx_valid_o is 1. This happens a few system cycles after that falling edge.
- R3: rx_valid_o is high for exactly one system cycle per received word.
- R4: The word loaded at frame start is driven on ser_tx_o, bit 15 first. Each bit appears on the rising edge that opens its bit period, starting with the period after the frame-sync period. ser_tx_o changes only right after a rising bit-clock edge.
- R5: A transmit word is accepted in a cycle where tx_valid_i and tx_ready_o are both 1. tx_ready_o then stays 0 until the next frame start moves the word into the transmit shifter.
- R6: If no word is held at frame start, the frame transmits all zeros and tx_underrun_o is 1 for one system cycle.
- R7: The transmit line is 0 in every bit period that does not carry a data bit.
- R8: In one frame, a received word and a transmitted word are carried at the same time, and neither disturbs the other.
- R9: A frame sync that arrives before a word is complete starts a new frame. The partial receive word is dropped and never strobed. The new frame sends the word held at that moment.
- R10: A frame sync may coincide with the sixteenth bit period of the previous word. That word is still delivered, and the next word starts in the following period, with no idle period between.
- R11: The port runs correctly for any bit-clock period of at least 8 system clock cycles. This covers the fast rate of about 15 MHz and the slow boot rate of 2.5 MHz at a 125 MHz system clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk_i | input | 1 | Host bit clock, free running |
| ser_fs_i | input | 1 | Host frame sync, one bit period high per word |
| ser_rx_i | input | 1 | Serial data from the host |
| ser_tx_o | output | 1 | Serial data to the host |
| rx_data_o | output | WORD_W | Last received word |
| rx_valid_o | output | 1 | One-cycle strobe, a new word is on rx_data_o |
| tx_data_i | input | WORD_W | Word to transmit |
| tx_valid_i | input | 1 | tx_data_i is valid |
| tx_ready_o | output | 1 | Holding register is free |
| tx_underrun_o | output | 1 | One-cycle pulse, a frame started with no word held |

## Verification
Directed single-bit words (only the top bit set, only the bottom bit set), all ones and an alternating pattern are sent both ways. These tell a correct most-significant-first order and bit-period alignment apart from reversed or shifted bit order. Random words then follow, with random gaps and random receive-line noise during the sync and idle periods. Some random frames deliberately have no transmit word, which separates the zero-fill and underrun path from normal loading. Truncated frames, back-to-back frames with the sync on the last bit, and a run at the slow boot rate each test the resync, overlap and clock-ratio cases that the steady pattern cannot reach.

// File: rtl/sslv_pkg.sv
package sslv_pkg;

    typedef enum logic [0:0] {
        RX_IDLE  = 1'b0,
        RX_SHIFT = 1'b1
    } rx_state_t;

    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,
        TX_ARMED = 2'd1,
        TX_SEND  = 2'd2
    } tx_state_t;

endpackage

// File: rtl/sslv_edge.sv
module sslv_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ser_clk_i,
    input  logic ser_fs_i,
    input  logic ser_rx_i,
    output logic rise_o,
    output logic fall_o,
    output logic fs_o,
    output logic rx_o
);
    localparam int LANES = 3;

    logic [LANES-1:0] raw;
    logic [LANES-1:0] synced;
    logic             clk_prev_q;

    assign raw = {ser_clk_i, ser_fs_i, ser_rx_i};

    // one synchronizer chain per host input, all of equal depth
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [SYNC_STAGES-1:0] chain_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain_q <= '0;
            end else begin
                chain_q <= (chain_q << 1) | SYNC_STAGES'(raw[g]);
            end
        end
        assign synced[g] = chain_q[SYNC_STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clk_prev_q <= 1'b0;
        end else begin
            clk_prev_q <= synced[2];
        end
    end

    assign rise_o = synced[2] & ~clk_prev_q;
    assign fall_o = ~synced[2] & clk_prev_q;
    assign fs_o   = synced[1];
    assign rx_o   = synced[0];

endmodule

// File: rtl/sslv_rx.sv
module sslv_rx
    import sslv_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fall_i,
    input  logic              fs_i,
    input  logic              rx_i,
    output logic [WORD_W-1:0] word_o,
    output logic              valid_o
);
    localparam int CNT_W = $clog2(WORD_W);

    rx_state_t          state_q, state_d;
    logic [CNT_W-1:0]   cnt_q;
    logic [WORD_W-1:0]  shift_q;
    logic [WORD_W-1:0]  shift_nx;
    logic               last_bit;

    assign last_bit = (state_q == RX_SHIFT) && (cnt_q == CNT_W'(WORD_W - 1));
    assign shift_nx = {shift_q[WORD_W-2:0], rx_i};

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RX_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: frame_start, word_done, resync
    always_comb begin
        state_d = state_q;
        if (fall_i) begin
            unique case (state_q)
                RX_IDLE:  if (fs_i) state_d = RX_SHIFT;
                RX_SHIFT: begin
                    if (fs_i)          state_d = RX_SHIFT;
                    else if (last_bit) state_d = RX_IDLE;
                end
                default:  state_d = RX_IDLE;
            endcase
        end
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            shift_q <= '0;
            word_o  <= '0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            if (fall_i) begin
                if (state_q == RX_SHIFT) begin
                    shift_q <= shift_nx;
                    cnt_q   <= cnt_q + CNT_W'(1);
                    if (last_bit) begin
                        word_o  <= shift_nx;
                        valid_o <= 1'b1;
                    end
                end
                if (fs_i) begin
                    cnt_q <= '0;
                end
            end
        end
    end

endmodule

// File: rtl/sslv_tx.sv
module sslv_tx
    import sslv_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rise_i,
    input  logic              fall_i,
    input  logic              fs_i,
    input  logic [WORD_W-1:0] data_i,
    input  logic              valid_i,
    output logic              ready_o,
    output logic              underrun_o,
    output logic              txd_o
);
    localparam int CNT_W = $clog2(WORD_W);

    tx_state_t          state_q, state_d;
    logic [CNT_W-1:0]   cnt_q;
    logic [WORD_W-1:0]  shift_q;
    logic [WORD_W-1:0]  hold_q;
    logic               hold_full_q;
    logic               frame_start;

    assign frame_start = fall_i & fs_i;
    assign ready_o     = ~hold_full_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TX_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: frame_start, first_bit, last_bit
    always_comb begin
        state_d = state_q;
        if (frame_start) begin
            state_d = TX_ARMED;
        end else if (rise_i) begin
            unique case (state_q)
                TX_IDLE:  state_d = TX_IDLE;
                TX_ARMED: state_d = TX_SEND;
                TX_SEND:  if (cnt_q == CNT_W'(WORD_W - 1)) state_d = TX_IDLE;
                default:  state_d = TX_IDLE;
            endcase
        end
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q       <= '0;
            shift_q     <= '0;
            hold_q      <= '0;
            hold_full_q <= 1'b0;
            underrun_o  <= 1'b0;
            txd_o       <= 1'b0;
        end else begin
            underrun_o <= 1'b0;
            if (valid_i && !hold_full_q) begin
                hold_q      <= data_i;
                hold_full_q <= 1'b1;
            end
            if (frame_start) begin
                cnt_q <= '0;
                if (hold_full_q) begin
                    shift_q     <= hold_q;
                    hold_full_q <= 1'b0;
                end else begin
                    shift_q    <= '0;
                    underrun_o <= 1'b1;
                end
            end else if (rise_i) begin
                if (state_q != TX_IDLE) begin
                    txd_o   <= shift_q[WORD_W-1];
                    shift_q <= {shift_q[WORD_W-2:0], 1'b0};
                    cnt_q   <= cnt_q + CNT_W'(1);
                end else begin
                    txd_o <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/sync_serial_slave.sv
module sync_serial_slave #(
    parameter int WORD_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk_i,
    input  logic              ser_fs_i,
    input  logic              ser_rx_i,
    output logic              ser_tx_o,
    output logic [WORD_W-1:0] rx_data_o,
    output logic              rx_valid_o,
    input  logic [WORD_W-1:0] tx_data_i,
    input  logic              tx_valid_i,
    output logic              tx_ready_o,
    output logic              tx_underrun_o
);
    logic ser_rise;
    logic ser_fall;
    logic fs_s;
    logic rx_s;

    sslv_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .ser_clk_i (ser_clk_i),
        .ser_fs_i  (ser_fs_i),
        .ser_rx_i  (ser_rx_i),
        .rise_o    (ser_rise),
        .fall_o    (ser_fall),
        .fs_o      (fs_s),
        .rx_o      (rx_s)
    );

    sslv_rx #(.WORD_W(WORD_W)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .fall_i  (ser_fall),
        .fs_i    (fs_s),
        .rx_i    (rx_s),
        .word_o  (rx_data_o),
        .valid_o (rx_valid_o)
    );

    sslv_tx #(.WORD_W(WORD_W)) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .rise_i     (ser_rise),
        .fall_i     (ser_fall),
        .fs_i       (fs_s),
        .data_i     (tx_data_i),
        .valid_i    (tx_valid_i),
        .ready_o    (tx_ready_o),
        .underrun_o (tx_underrun_o),
        .txd_o      (ser_tx_o)
    );

endmodule

// File: rtl/sslv_chk.sv
module sslv_chk (
    input logic clk,
    input logic rst_n,
    input logic ser_rise,
    input logic ser_fall,
    input logic ser_tx_o,
    input logic rx_valid_o,
    input logic tx_valid_i,
    input logic tx_ready_o,
    input logic tx_underrun_o
);
    // R2: a word strobe follows a detected falling bit-clock edge
    a_r2_valid_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |-> $past(ser_fall));

    // R3: strobe lasts one cycle
    a_r3_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |=> !rx_valid_o);

    // R4: the transmit line moves only after a rising bit-clock edge
    a_r4_tx_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ser_tx_o) |-> $past(ser_rise));

    // R5: an accepted word makes the holding register busy
    a_r5_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid_i && tx_ready_o) |=> !tx_ready_o);

    // R6: underrun is a single-cycle pulse
    a_r6_underrun_single: assert property (@(posedge clk) disable iff (!rst_n)
        tx_underrun_o |=> !tx_underrun_o);

endmodule

bind sync_serial_slave sslv_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ser_rise      (ser_rise),
    .ser_fall      (ser_fall),
    .ser_tx_o      (ser_tx_o),
    .rx_valid_o    (rx_valid_o),
    .tx_valid_i    (tx_valid_i),
    .tx_ready_o    (tx_ready_o),
    .tx_underrun_o (tx_underrun_o)
);

// File: tb/sync_serial_slave_tb.sv
`timescale 1ns/1ps
module sync_serial_slave_tb;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ser_clk_i = 1'b0;
    logic         ser_fs_i = 1'b0;
    logic         ser_rx_i = 1'b0;
    logic         ser_tx_o;
    logic [W-1:0] rx_data_o;
    logic         rx_valid_o;
    logic [W-1:0] tx_data_i = '0;
    logic         tx_valid_i = 1'b0;
    logic         tx_ready_o;
    logic         tx_underrun_o;

    int checks = 0;
    int errors = 0;
    int half   = 4;
    int rx_cnt = 0;
    int ur_cnt = 0;
    logic [W-1:0] rx_last = '0;

    always #4 clk = ~clk;

    sync_serial_slave #(.WORD_W(W)) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .ser_clk_i     (ser_clk_i),
        .ser_fs_i      (ser_fs_i),
        .ser_rx_i      (ser_rx_i),
        .ser_tx_o      (ser_tx_o),
        .rx_data_o     (rx_data_o),
        .rx_valid_o    (rx_valid_o),
        .tx_data_i     (tx_data_i),
        .tx_valid_i    (tx_valid_i),
        .tx_ready_o    (tx_ready_o),
        .tx_underrun_o (tx_underrun_o)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_valid_o) begin
                rx_cnt  = rx_cnt + 1;
                rx_last = rx_data_o;
            end
            if (tx_underrun_o) ur_cnt = ur_cnt + 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one host bit period; host drives on the rising edge, samples tx before falling
    task automatic do_bit(input logic fs_v, input logic rx_v, output logic tx_v);
        ser_clk_i = 1'b1;
        ser_fs_i  = fs_v;
        ser_rx_i  = rx_v;
        repeat (half) @(negedge clk);
        tx_v = ser_tx_o;
        ser_clk_i = 1'b0;
        repeat (half) @(negedge clk);
    endtask

    task automatic idle_bits(input int n, input string req);
        logic t;
        for (int i = 0; i < n; i++) begin
            do_bit(1'b0, 1'($urandom % 2), t);
            chk(req, 32'(t), 32'd0);
        end
    endtask

    task automatic push(input logic [W-1:0] w);
        while (!tx_ready_o) @(negedge clk);
        tx_data_i  = w;
        tx_valid_i = 1'b1;
        @(negedge clk);
        tx_valid_i = 1'b0;
    endtask

    task automatic frame(input logic [W-1:0] rxw, output logic [W-1:0] txw);
        logic t;
        do_bit(1'b1, 1'($urandom % 2), t);
        for (int i = W - 1; i >= 0; i--) begin
            do_bit(1'b0, rxw[i], t);
            txw[i] = t;
        end
    endtask

    // full frame with model: expected tx word or zero with underrun
    task automatic one_frame(input logic [W-1:0] rxw, input bit have, input logic [W-1:0] txv,
                             input int gap, input string tag);
        logic [W-1:0] got;
        int rc0;
        int uc0;
        if (have) push(txv);
        rc0 = rx_cnt;
        uc0 = ur_cnt;
        frame(rxw, got);
        idle_bits(gap, {"R7 idle line ", tag});
        chk({"R2 rx count ", tag}, 32'(rx_cnt), 32'(rc0 + 1));
        chk({"R2 rx word ", tag}, 32'(rx_last), 32'(rxw));
        if (have) begin
            chk({"R4 tx word ", tag}, 32'(got), 32'(txv));
            chk({"R8 duplex rx+tx ", tag}, 32'({rx_last, got}), 32'({rxw, txv}));
        end else begin
            chk({"R6 zero word ", tag}, 32'(got), 32'd0);
        end
        chk({"R6 underrun count ", tag}, 32'(ur_cnt), 32'(uc0 + (have ? 0 : 1)));
    endtask

    task automatic run_all();
        logic t;
        logic [W-1:0] got;
        logic [W-1:0] wa;
        logic [W-1:0] wb;
        int rc0;
        int uc0;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 tx line", 32'(ser_tx_o), 32'd0);
        chk("R1 rx_valid", 32'(rx_valid_o), 32'd0);
        chk("R1 tx_ready", 32'(tx_ready_o), 32'd1);
        chk("R1 underrun", 32'(tx_underrun_o), 32'd0);
        idle_bits(2, "R7 before first frame");

        // directed bit-order patterns at the fast rate (R11: 8 system cycles per bit)
        one_frame(16'h8000, 1'b1, 16'h0001, 1, "msb");
        one_frame(16'h0001, 1'b1, 16'h8000, 1, "lsb");
        one_frame(16'hFFFF, 1'b1, 16'hFFFF, 1, "ones");
        one_frame(16'hA5A5, 1'b1, 16'h5A5A, 1, "alt");
        one_frame(16'h1234, 1'b0, 16'h0000, 1, "R6 empty");

        // R5: handshake holds off a second word until frame start
        push(16'hC3C3);
        chk("R5 ready low after accept", 32'(tx_ready_o), 32'd0);
        do_bit(1'b1, 1'b0, t);
        repeat (2) @(negedge clk);
        chk("R5 ready back after frame start", 32'(tx_ready_o), 32'd1);
        for (int i = W - 1; i >= 0; i--) begin
            do_bit(1'b0, 1'b0, t);
            got[i] = t;
        end
        chk("R5 handed word sent", 32'(got), 32'hC3C3);
        idle_bits(1, "R7 after R5 frame");

        // R9: frame sync mid-word restarts
        wa = 16'hF00D; wb = 16'h6E21;
        push(wa);
        rc0 = rx_cnt; uc0 = ur_cnt;
        do_bit(1'b1, 1'b0, t);
        for (int i = 0; i < 7; i++) begin
            do_bit(1'b0, 1'b1, t);
            if (i == 1) push(wb);
        end
        do_bit(1'b1, 1'b1, t);
        for (int i = W - 1; i >= 0; i--) begin
            do_bit(1'b0, wb[i], t);
            got[i] = t;
        end
        idle_bits(1, "R7 after R9 frame");
        chk("R9 one word only", 32'(rx_cnt), 32'(rc0 + 1));
        chk("R9 rx word is new frame", 32'(rx_last), 32'(wb));
        chk("R9 tx word is held word", 32'(got), 32'(wb));
        chk("R9 no underrun", 32'(ur_cnt), 32'(uc0));

        // R10: back-to-back, sync on the last bit of the previous word
        wa = 16'h0FF1; wb = 16'hB00C;
        push(wa);
        rc0 = rx_cnt; uc0 = ur_cnt;
        do_bit(1'b1, 1'b0, t);
        for (int i = W - 1; i >= 0; i--) begin
            do_bit(i == 0, wa[i], t);
            got[i] = t;
            if (i == 8) push(wb);
        end
        chk("R10 first tx word", 32'(got), 32'(wa));
        for (int i = W - 1; i >= 0; i--) begin
            do_bit(1'b0, wb[i], t);
            got[i] = t;
        end
        chk("R10 second tx word", 32'(got), 32'(wb));
        idle_bits(1, "R7 after R10 frames");
        chk("R10 two words", 32'(rx_cnt), 32'(rc0 + 2));
        chk("R10 last rx word", 32'(rx_last), 32'(wb));
        chk("R10 no underrun", 32'(ur_cnt), 32'(uc0));

        // random frames at the fast rate
        for (int f = 0; f < 80; f++) begin
            logic [W-1:0] rw;
            logic [W-1:0] tw;
            bit have;
            rw = W'($urandom);
            tw = W'($urandom);
            have = ($urandom % 10) < 7;
            one_frame(rw, have, tw, 1 + int'($urandom % 3), "R11 fast random");
        end

        // random frames at the slow boot rate
        half = 25;
        for (int f = 0; f < 20; f++) begin
            logic [W-1:0] rw;
            logic [W-1:0] tw;
            bit have;
            rw = W'($urandom);
            tw = W'($urandom);
            have = ($urandom % 10) < 7;
            one_frame(rw, have, tw, 1 + int'($urandom % 2), "R11 slow random");
        end
    endtask

    initial begin
        void'($urandom(32'h5EED_0A11));
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog R1-all actual=timeout expected=finish");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule